// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Controller

This block gathers 32 interrupt lines into one request line for a processor. Each line can be set up on its own as edge or level sensitive, and as active high (rising) or active low (falling). A qualifying event sets a per-line pending latch. The latch stays set until software acknowledges it. Software reaches the block through a simple port with valid, write, address and data signals. That port gives access to an enable mask, a write-one-to-acknowledge register, a trigger-mode mask, a polarity mask and a read-only status view showing lines that are both pending and enabled.

Each input line passes through a two-flop synchroniser before detection. Each line then runs a two-state machine. `SRC_IDLE` moves to `SRC_PENDING` on the latch transition, which happens when the line sees its active level (level mode) or a new active edge (edge mode). `SRC_PENDING` moves back to `SRC_IDLE` on the release transition, which is an acknowledge. An acknowledge on a level line always wins over the line's own event in that cycle. An acknowledge on an edge line loses to a new edge in the same cycle. Every other case holds the state.

The output request is driven by a second two-state machine. `IRQ_QUIET` moves to `IRQ_RAISED` on the raise transition, which happens when any status bit is set. `IRQ_RAISED` moves back to `IRQ_QUIET` on the lower transition, which happens when every status bit is clear.

Top module: `trigmask_intc`

## Requirements
- R1: After reset the enable mask is all zeros and the mode mask is all zeros (level). The polarity mask is all ones, no line is pending, `irq_o` is low and a status read returns zero.
- R2: The address map is 0 enable, 1 acknowledge, 2 mode, 3 polarity, 4 status. Reading 0, 2 or 3 returns the register's contents, and reading 1 or any unused address returns zero. `rd_data_o` is loaded at the clock edge that accepts a read (valid high, write low).
- R3: In the mode mask, bit k = 1 makes line k edge triggered and 0 makes it level triggered. In the polarity mask, bit k = 1 selects active low (falling edge) and 0 selects active high (rising edge). An input change first seen at clock edge E0 makes the line pending at edge E0+2.
- R4: Level and edge lines both stay pending after the input returns to its inactive level, until they are acknowledged.
- R5: Writing to address 1 clears the pending latch of every line whose data bit is 1. Lines whose data bit is 0 are not affected.
- R6: If a level line is acknowledged while its input is still active, a status read in the next cycle shows it clear, and a read one cycle later shows it pending again.
- R7: An acknowledge on an edge line discards its earlier event. If the input is held active afterwards, the line is not pending again; only a new active edge sets it.
- R8: If an acknowledge arrives on an edge line in the same cycle as a new active edge on that line, the line remains pending.
- R9: The status view is pending AND enabled. A disabled line never shows in it, but it keeps its pending latch, so the line appears in the status view once it is enabled.
- R10: `irq_o` is a register holding the OR of the status bits. It rises one cycle after any status bit is set and falls one cycle after the last one clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| src_i | input | 32 | Asynchronous interrupt lines |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 3 | Register select |
| req_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, loaded at the accepting edge |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A line's state machine stuck in the wrong state shows up in two places: on the next status read, and one cycle later on `irq_o`. The most revealing windows are the single cycle just after an acknowledge and the exact cycle where an acknowledge meets a new edge. Sweeping every line through all four mode and polarity combinations exposes a polarity or mode bit routed to the wrong line. It also exposes a lost latch, within two cycles of the input change or the acknowledge. A mask fault appears as a status bit set for a disabled line, or as an enabled line that is missing from the status view.

// File: rtl/trigmask_intc_pkg.sv
package trigmask_intc_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE   = 3'd0,
        REG_ACK      = 3'd1,
        REG_MODE     = 3'd2,
        REG_POLARITY = 3'd3,
        REG_STATUS   = 3'd4
    } reg_sel_e;

    typedef enum logic {
        SRC_IDLE    = 1'b0,
        SRC_PENDING = 1'b1
    } src_state_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/trigmask_intc_sync.sv
module trigmask_intc_sync #(
    parameter int   WIDTH   = 32,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= {(STAGES*WIDTH){RST_VAL}};
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/trigmask_intc_cell.sv
module trigmask_intc_cell
    import trigmask_intc_pkg::*;
#(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic sync_i,
    input  logic edge_mode_i,
    input  logic active_low_i,
    input  logic ack_i,
    output logic pend_o
);
    logic       prev_q;
    logic       now_act;
    logic       was_act;
    logic       trig;
    src_state_e state_q;
    src_state_e state_d;

    // Previous sample is kept raw; polarity is applied to both samples alike,
    // so a polarity rewrite never fakes an edge.
    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= RST_VAL;
        else       prev_q <= sync_i;
    end

    assign now_act = sync_i ^ active_low_i;
    assign was_act = prev_q ^ active_low_i;
    assign trig    = edge_mode_i ? (now_act & ~was_act) : now_act;

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= SRC_IDLE;
        else       state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: begin
                // latch: level ack in the same cycle suppresses it
                if (trig && (edge_mode_i || !ack_i)) state_d = SRC_PENDING;
            end
            SRC_PENDING: begin
                // release: a coinciding new edge keeps the latch
                if (ack_i && !(edge_mode_i && trig)) state_d = SRC_IDLE;
            end
            default: state_d = SRC_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == SRC_PENDING);
    end

    AST_LEVEL_ACK_DROPS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!edge_mode_i && ack_i) |=> !pend_o); // R6
    AST_EDGE_BEATS_ACK: assert property (@(posedge clk_i) disable iff (rst_i)
        (edge_mode_i && ack_i && trig) |=> pend_o); // R8
    AST_LATCH_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pend_o) |-> $past(trig)); // R3
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_o && !ack_i) |=> pend_o); // R4
endmodule

// File: rtl/trigmask_intc_regs.sv
module trigmask_intc_regs
    import trigmask_intc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [NSRC-1:0]   req_wdata_i,
    input  logic [NSRC-1:0]   status_i,
    output logic [NSRC-1:0]   en_o,
    output logic [NSRC-1:0]   mode_o,
    output logic [NSRC-1:0]   pol_o,
    output logic [NSRC-1:0]   ack_o,
    output logic [NSRC-1:0]   rd_data_o
);
    logic wr_hit;
    logic rd_hit;
    logic [NSRC-1:0] rd_mux;

    assign wr_hit = req_valid_i &&  req_write_i;
    assign rd_hit = req_valid_i && !req_write_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_o   <= '0;
            mode_o <= '0;
            pol_o  <= '1;
        end else if (wr_hit) begin
            if (req_addr_i == REG_ENABLE)   en_o   <= req_wdata_i;
            if (req_addr_i == REG_MODE)     mode_o <= req_wdata_i;
            if (req_addr_i == REG_POLARITY) pol_o  <= req_wdata_i;
        end
    end

    assign ack_o = (wr_hit && req_addr_i == REG_ACK) ? req_wdata_i : '0;

    always_comb begin
        rd_mux = '0;
        unique case (req_addr_i)
            REG_ENABLE:   rd_mux = en_o;
            REG_MODE:     rd_mux = mode_o;
            REG_POLARITY: rd_mux = pol_o;
            REG_STATUS:   rd_mux = status_i;
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)       rd_data_o <= '0;
        else if (rd_hit) rd_data_o <= rd_mux;
    end

    AST_RESET_STATE: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (en_o == '0 && mode_o == '0 && pol_o == '1)); // R1
    AST_ACK_READS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_hit && req_addr_i == REG_ACK) |=> (rd_data_o == '0)); // R2
endmodule

// File: rtl/trigmask_intc.sv
module trigmask_intc
    import trigmask_intc_pkg::*;
#(
    parameter int   NSRC         = 32,
    parameter int   SYNC_STAGES  = 2,
    parameter logic SYNC_RST_VAL = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NSRC-1:0]   src_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [NSRC-1:0]   req_wdata_i,
    output logic [NSRC-1:0]   rd_data_o,
    output logic              irq_o
);
    logic [NSRC-1:0] sync_w;
    logic [NSRC-1:0] en_w;
    logic [NSRC-1:0] mode_w;
    logic [NSRC-1:0] pol_w;
    logic [NSRC-1:0] ack_w;
    logic [NSRC-1:0] pend_w;
    logic [NSRC-1:0] status_w;
    irq_state_e      irq_q;
    irq_state_e      irq_d;

    trigmask_intc_sync #(
        .WIDTH  (NSRC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST_VAL)
    ) u_sync (
        .clk_i(clk_i),
        .rst_i(rst_i),
        .d_i  (src_i),
        .q_o  (sync_w)
    );

    trigmask_intc_regs #(.NSRC(NSRC)) u_regs (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .req_valid_i(req_valid_i),
        .req_write_i(req_write_i),
        .req_addr_i (req_addr_i),
        .req_wdata_i(req_wdata_i),
        .status_i   (status_w),
        .en_o       (en_w),
        .mode_o     (mode_w),
        .pol_o      (pol_w),
        .ack_o      (ack_w),
        .rd_data_o  (rd_data_o)
    );

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        trigmask_intc_cell #(.RST_VAL(SYNC_RST_VAL)) u_cell (
            .clk_i       (clk_i),
            .rst_i       (rst_i),
            .sync_i      (sync_w[k]),
            .edge_mode_i (mode_w[k]),
            .active_low_i(pol_w[k]),
            .ack_i       (ack_w[k]),
            .pend_o      (pend_w[k])
        );
    end

    assign status_w = pend_w & en_w;

    always_ff @(posedge clk_i) begin
        if (rst_i) irq_q <= IRQ_QUIET;
        else       irq_q <= irq_d;
    end

    always_comb begin
        irq_d = irq_q;
        unique case (irq_q)
            IRQ_QUIET:  if (|status_w)  irq_d = IRQ_RAISED;   // raise
            IRQ_RAISED: if (~|status_w) irq_d = IRQ_QUIET;    // lower
            default:    irq_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (irq_q == IRQ_RAISED);
    end

    AST_IRQ_RISES: assert property (@(posedge clk_i) disable iff (rst_i)
        (|status_w) |=> irq_o); // R10
    AST_IRQ_FALLS: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_w == '0) |=> !irq_o); // R10
    AST_STATUS_MASKED: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && !req_write_i && req_addr_i == REG_STATUS)
        |=> ((rd_data_o & ~$past(en_w)) == '0)); // R9
endmodule

// File: tb/trigmask_intc_tb_top.sv
module trigmask_intc_tb_top;
    import trigmask_intc_pkg::*;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] src;
    logic         valid;
    logic         write;
    logic [2:0]   addr;
    logic [N-1:0] wdata;
    logic [N-1:0] rdata;
    logic         irq;
    int           n_cmp = 0;
    int           n_bad = 0;
    bit           done  = 1'b0;

    always #5 clk = ~clk;

    trigmask_intc dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .src_i      (src),
        .req_valid_i(valid),
        .req_write_i(write),
        .req_addr_i (addr),
        .req_wdata_i(wdata),
        .rd_data_o  (rdata),
        .irq_o      (irq)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic bus_wr(input logic [2:0] a, input logic [N-1:0] d);
        valid = 1'b1; write = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        valid = 1'b0; write = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [N-1:0] d);
        valid = 1'b1; write = 1'b0; addr = a;
        @(negedge clk);
        valid = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_case(input int i, input bit m, input bit p);
        logic [N-1:0] r;
        logic [N-1:0] oh;
        string        cfg;
        oh  = N'(1) << i;
        cfg = $sformatf("line %0d mode %0d pol %0d", i, m, p);
        src = {N{p}};
        bus_wr(REG_ENABLE, '0);
        bus_wr(REG_MODE, {N{m}});
        bus_wr(REG_POLARITY, {N{p}});
        idle(4);
        bus_wr(REG_ACK, '1);
        src[i] = ~p;
        idle(4);
        bus_rd(REG_STATUS, r);
        chk({"R9 disabled line hidden ", cfg}, r, '0);
        chk({"R9 irq low while disabled ", cfg}, N'(irq), '0);
        bus_wr(REG_ENABLE, oh);
        bus_rd(REG_STATUS, r);
        chk({"R3 R9 latched shown on enable ", cfg}, r, oh);
        chk({"R10 irq raised ", cfg}, N'(irq), N'(1));
        src[i] = p;
        idle(4);
        bus_rd(REG_STATUS, r);
        chk({"R4 stays pending ", cfg}, r, oh);
        bus_wr(REG_ACK, ~oh);
        bus_rd(REG_STATUS, r);
        chk({"R5 zero bits no effect ", cfg}, r, oh);
        bus_wr(REG_ACK, oh);
        bus_rd(REG_STATUS, r);
        chk({"R5 ack clears ", cfg}, r, '0);
        chk({"R10 irq lowered ", cfg}, N'(irq), '0);
        src[i] = ~p;
        idle(4);
        bus_rd(REG_STATUS, r);
        chk({"R3 second event ", cfg}, r, oh);
        bus_wr(REG_ACK, oh);
        bus_rd(REG_STATUS, r);
        if (!m) begin
            chk({"R6 clear in cycle after ack ", cfg}, r, '0);
            bus_rd(REG_STATUS, r);
            chk({"R6 relatched while active ", cfg}, r, oh);
        end else begin
            chk({"R7 ack discards edge ", cfg}, r, '0);
            idle(4);
            bus_rd(REG_STATUS, r);
            chk({"R7 held level no relatch ", cfg}, r, '0);
            src[i] = p;
            idle(4);
            src[i] = ~p;
            idle(4);
            bus_rd(REG_STATUS, r);
            chk({"R7 new edge latches ", cfg}, r, oh);
            src[i] = p;
            idle(4);
            src[i] = ~p;
            idle(2);
            bus_wr(REG_ACK, oh);
            bus_rd(REG_STATUS, r);
            chk({"R8 edge beats ack ", cfg}, r, oh);
        end
        src[i] = p;
        idle(4);
        bus_wr(REG_ACK, '1);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [N-1:0] r;
        src = '1; valid = 1'b0; write = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 irq low after reset", N'(irq), '0);
        bus_rd(REG_ENABLE, r);   chk("R1 enable reset", r, '0);
        bus_rd(REG_MODE, r);     chk("R1 mode reset", r, '0);
        bus_rd(REG_POLARITY, r); chk("R1 polarity reset", r, '1);
        bus_rd(REG_STATUS, r);   chk("R1 status reset", r, '0);
        bus_rd(REG_ACK, r);      chk("R2 ack reads zero", r, '0);
        bus_wr(REG_MODE, 32'h9C3A_5E71);
        bus_rd(REG_MODE, r);     chk("R2 mode readback", r, 32'h9C3A_5E71);
        bus_wr(REG_POLARITY, 32'h1234_ABCD);
        bus_rd(REG_POLARITY, r); chk("R2 polarity readback", r, 32'h1234_ABCD);
        bus_wr(REG_ENABLE, 32'h0F0F_F0F0);
        bus_rd(REG_ENABLE, r);   chk("R2 enable readback", r, 32'h0F0F_F0F0);
        bus_rd(3'd5, r);         chk("R2 unused address reads zero", r, '0);
        bus_rd(3'd7, r);         chk("R2 unused address reads zero", r, '0);
        for (int i = 0; i < N; i++) begin
            for (int c = 0; c < 4; c++) begin
                run_case(i, c[1], c[0]);
            end
        end
        summary();
        $finish;
    end
endmodule